// File: doc/BRIEF.md
# Dual-Copy Cross-Clock Register

This block keeps one data register that two unrelated clock domains share. The writer domain owns a local copy, and every write strobe updates that copy. The value is visible on the writer-side read port one cycle later, with no synchronisation in the way. The reader domain owns a second copy. It is refreshed through a toggle request/acknowledge handshake, and each leg of the handshake passes through a multi-flop synchroniser in the domain that receives it.

When the writer strobes a value while no transfer is pending, that value goes into a holding register and the request line toggles. The reader detects the toggle, loads the holding register into its own copy, and raises a one-cycle new-value flag. It then returns the toggle as the acknowledge. Writes that arrive while a transfer is still in flight update only the writer copy and never reach the reader. The reader therefore sees only completed transfers. Two clocks of equal frequency from different sources are treated as unrelated.

Top module: `xdom_reg`

## Requirements
- R1: While the resets are asserted and after they are released, `wr_local` and `rd_data` equal `RESET_VAL` and `rd_new` is 0.
- R2: A write strobe in writer cycle N makes `wr_local` equal the written data from cycle N+1 onward, with no dependence on the reader clock.
- R3: `rd_data` changes only in a reader cycle where `rd_new` is 1, and after an accepted write it settles to exactly the accepted value.
- R4: `rd_new` is high for exactly one reader cycle per completed transfer and is never high in two consecutive reader cycles.
- R5: A write made while a transfer is in flight updates `wr_local` but is dropped for the reader, and the holding register stays unchanged until the acknowledge returns.
- R6: `rd_data` never reflects a write within the same writer cycle in which the write lands; the value must first cross the request synchroniser.
- R7: Once the acknowledge has returned, the next write is accepted and transferred, whether the reader clock is faster, slower or the same frequency with an unrelated phase.
- R8: The internal request line toggles only on a writer cycle that carried a write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Writer-domain clock |
| wrst_n | input | 1 | Writer-domain asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Data to write |
| wr_local | output | WIDTH | Writer-domain copy, one cycle after a write |
| rclk | input | 1 | Reader-domain clock |
| rrst_n | input | 1 | Reader-domain asynchronous reset, active low |
| rd_data | output | WIDTH | Reader-domain copy |
| rd_new | output | 1 | One-cycle pulse when `rd_data` is refreshed |

## Verification
The bench builds the block with WIDTH=4, SYNC_STAGES=2 and RESET_VAL=4'hA. The narrow word lets every one of the 16 codes cross the boundary in each of three clock relationships: a reader at 17 ns, a reader at 7 ns, and a reader at 10 ns offset by 3 ns. Each pass also forces back-to-back writes to show that the second write is dropped for the reader while it is still kept in the writer's own copy.

// File: rtl/xreg_pkg.sv
package xreg_pkg;
   localparam int unsigned XREG_MIN_SYNC = 2;
   localparam int unsigned XREG_MAX_SYNC = 6;
endpackage

// File: rtl/xreg_sync.sv
module xreg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import xreg_pkg::*;

   generate
      if (STAGES < XREG_MIN_SYNC || STAGES > XREG_MAX_SYNC) begin : g_bad
         $error("xreg_sync: STAGES out of range");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xreg_wside.sv
module xreg_wside #(
   parameter int unsigned     WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             ack_s,
   output logic             req_t,
   output logic [WIDTH-1:0] hold,
   output logic [WIDTH-1:0] local_q
);
   logic busy;
   assign busy = req_t ^ ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         local_q <= RESET_VAL;
         hold    <= RESET_VAL;
         req_t   <= 1'b0;
      end else if (wr_en) begin
         local_q <= wr_data;
         if (!busy) begin
            hold  <= wr_data;
            req_t <= ~req_t;
         end
      end
   end
endmodule

// File: rtl/xreg_rside.sv
module xreg_rside #(
   parameter int unsigned     WIDTH     = 8,
   parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_s,
   input  logic [WIDTH-1:0] hold,
   output logic             ack_t,
   output logic [WIDTH-1:0] rd_q,
   output logic             rd_new
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_t  <= 1'b0;
         rd_q   <= RESET_VAL;
         rd_new <= 1'b0;
      end else if (req_s != ack_t) begin
         ack_t  <= req_s;
         rd_q   <= hold;
         rd_new <= 1'b1;
      end else begin
         rd_new <= 1'b0;
      end
   end
endmodule

// File: rtl/xdom_reg.sv
module xdom_reg #(
   parameter int unsigned      WIDTH       = 8,
   parameter int unsigned      SYNC_STAGES = 2,
   parameter logic [WIDTH-1:0] RESET_VAL   = '0
) (
   input  logic             wclk,
   input  logic             wrst_n,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] wr_local,
   input  logic             rclk,
   input  logic             rrst_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             rd_new
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xdom_reg: WIDTH must be at least 1");
      end
   endgenerate

   logic             req_t, req_s, ack_t, ack_s;
   logic [WIDTH-1:0] hold;

   xreg_wside #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_w (
      .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
      .ack_s(ack_s), .req_t(req_t), .hold(hold), .local_q(wr_local));

   xreg_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(rclk), .rst_n(rrst_n), .d(req_t), .q(req_s));

   xreg_rside #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL)) u_r (
      .clk(rclk), .rst_n(rrst_n), .req_s(req_s), .hold(hold),
      .ack_t(ack_t), .rd_q(rd_data), .rd_new(rd_new));

   xreg_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(wclk), .rst_n(wrst_n), .d(ack_t), .q(ack_s));
endmodule

// File: rtl/xdom_reg_chk.sv
module xdom_reg_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             wclk,
   input logic             wrst_n,
   input logic             wr_en,
   input logic [WIDTH-1:0] wr_data,
   input logic [WIDTH-1:0] wr_local,
   input logic             rclk,
   input logic             rrst_n,
   input logic [WIDTH-1:0] rd_data,
   input logic             rd_new,
   input logic             req_t,
   input logic             ack_s,
   input logic [WIDTH-1:0] hold
);
   p_local_next_r2: assert property (@(posedge wclk) disable iff (!wrst_n)
      wr_en |=> wr_local == $past(wr_data));

   p_rd_change_flagged_r3: assert property (@(posedge rclk) disable iff (!rrst_n)
      !$stable(rd_data) |-> rd_new);

   p_new_single_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
      rd_new |=> !rd_new);

   p_hold_frozen_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
      (req_t != ack_s) |=> $stable(hold));

   p_req_from_write_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
      !$stable(req_t) |-> $past(wr_en));
endmodule

bind xdom_reg xdom_reg_chk #(.WIDTH(WIDTH)) u_chk (
   .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
   .wr_local(wr_local), .rclk(rclk), .rrst_n(rrst_n), .rd_data(rd_data),
   .rd_new(rd_new), .req_t(req_t), .ack_s(ack_s), .hold(hold));

// File: tb/tb_xdom_reg.sv
`timescale 1ns/1ps
module tb_xdom_reg;
   localparam int unsigned W = 4;
   localparam logic [W-1:0] RV = 4'hA;

   logic wclk = 1'b0, rclk = 1'b0, wrst_n = 1'b0, rrst_n = 1'b0, wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] wr_local, rd_data;
   logic rd_new;
   real rhalf = 8.5;
   int checks = 0, errors = 0, pulses = 0;
   bit done = 1'b0;

   xdom_reg #(.WIDTH(W), .SYNC_STAGES(2), .RESET_VAL(RV)) dut (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
      .wr_local(wr_local), .rclk(rclk), .rrst_n(rrst_n),
      .rd_data(rd_data), .rd_new(rd_new));

   always #5 wclk = ~wclk;
   initial begin
      #3;
      forever #(rhalf) rclk = ~rclk;
   end

   always @(posedge rclk) if (rd_new) pulses++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [W-1:0] v);
      @(negedge wclk); wr_en = 1'b1; wr_data = v;
      @(negedge wclk); wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (40) @(negedge wclk);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] prev;
      repeat (4) @(negedge wclk);
      chk(rd_data == RV, "R1 rd_data in reset", rd_data, RV);
      chk(wr_local == RV, "R1 wr_local in reset", wr_local, RV);
      wrst_n = 1'b1; rrst_n = 1'b1;
      settle();
      chk(rd_data == RV && wr_local == RV, "R1 after release", rd_data, RV);
      chk(pulses == 0, "R1 rd_new idle", pulses, 0);
      for (int p = 0; p < 3; p++) begin
         rhalf = (p == 0) ? 8.5 : (p == 1) ? 3.5 : 5.0;
         settle();
         for (int v = 0; v < 16; v++) begin
            prev = rd_data;
            pulses = 0;
            @(negedge wclk); wr_en = 1'b1; wr_data = W'(v);
            @(negedge wclk); wr_en = 1'b0;
            chk(wr_local == W'(v), "R2 local copy", wr_local, v);
            chk(rd_data == prev, "R6 no early update", rd_data, prev);
            settle();
            chk(rd_data == W'(v), "R3 R7 transferred value", rd_data, v);
            chk(pulses == 1, "R4 one pulse", pulses, 1);
         end
         pulses = 0;
         @(negedge wclk); wr_en = 1'b1; wr_data = 4'h3;
         @(negedge wclk); wr_data = 4'hC;
         @(negedge wclk); wr_en = 1'b0;
         chk(wr_local == 4'hC, "R5 writer keeps latest", wr_local, 4'hC);
         settle();
         chk(rd_data == 4'h3, "R5 in-flight write dropped", rd_data, 4'h3);
         chk(pulses == 1, "R5 one transfer", pulses, 1);
         pulses = 0;
         wr(4'h6);
         settle();
         chk(rd_data == 4'h6 && pulses == 1, "R7 accepted after ack", rd_data, 4'h6);
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule